// File: doc/BRIEF.md
# Trap Entry State Save Unit

This unit performs the state-saving half of trap entry for a processor with register windows. When the pipeline raises a single-cycle trap request with a 9-bit trap type, the unit captures the live architectural state (program counter, next program counter, condition codes, address space identifier, processor state, hyper-state, window pointer and global level). It stores that state into a per-level stack of save registers and raises the trap level. In the same step it produces the new processor-state flags, the new global level and the new window pointer.

The window pointer moves by an amount chosen from the trap-type range. A clean-window trap advances it by one. A spill trap advances it past the windows that can still be saved. A fill trap moves it back by one. Every result wraps modulo the number of windows. A read port returns the saved words of any trap level so that later logic can restore them. Once the trap level has reached its ceiling, a further request is refused: the unit flags an error and leaves every register as it was.

Top module: `trap_entry`

## Requirements
- R1: A synchronous active-high reset sets the trap level, global level, window pointer, processor-state output and error flag to zero, and every saved level reads back as zero.
- R2: An accepted trap raises the trap level by one on the next clock edge, and the state is stored at that new level. The read port returns the saved words of levels 1 to MAX_TL and returns zeros for any other level.
- R3: The saved trap-state word places GL in bits 42:40, CCR in bits 39:32, ASI in bits 31:24, the 13-bit processor state in bits 20:8 and CWP in bits 4:0. All other bits are zero.
- R4: The saved trap PC and trap NPC of the new level equal the PC and NPC presented with the request. The saved hyper-state equals the HPSTATE input, and the saved trap type equals the request's trap type.
- R5: The new processor state has bit 4 set, bit 3 cleared, bit 2 set and bit 1 cleared.
- R6: Bit 9 of the new processor state takes the value of input bit 8. Bit 8 and every bit not named in R5 keep their input values.
- R7: Trap type 0x024 sets the new window pointer to the input CWP plus one.
- R8: A trap type from 0x080 to 0x0BF sets the new window pointer to the input CWP plus CANSAVE plus two.
- R9: A trap type from 0x0C0 to 0x0FF sets the new window pointer to the input CWP minus one. Any other trap type passes the input CWP through unchanged.
- R10: Every adjusted window pointer is reduced modulo NWIN, so the output always lies below NWIN.
- R11: The new global level is the input GL plus one, limited to MAX_GL.
- R12: A request that arrives while the trap level equals MAX_TL raises the error output for exactly one cycle. The trap level, the live outputs and all saved levels stay unchanged.
- R13: Without a request, the trap level, global level, window pointer and processor-state outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_i | input | 1 | Single-cycle trap request |
| tt_i | input | 9 | Trap type |
| pc_i | input | PC_W | Live program counter |
| npc_i | input | PC_W | Live next program counter |
| ccr_i | input | 8 | Live condition codes |
| asi_i | input | 8 | Live address space identifier |
| pstate_i | input | 13 | Live processor state |
| hpstate_i | input | 12 | Live hyper-state |
| cwp_i | input | 5 | Live window pointer |
| cansave_i | input | 5 | Count of windows that can still be saved |
| gl_i | input | 3 | Live global level |
| rd_lvl_i | input | TL_W | Trap level selected by the read port |
| tl_o | output | TL_W | Current trap level |
| gl_o | output | 3 | Global level after the last trap |
| cwp_o | output | 5 | Window pointer after the last trap |
| pstate_o | output | 13 | Processor state after the last trap |
| err_o | output | 1 | One-cycle pulse for a trap refused at MAX_TL |
| rd_tstate_o | output | 64 | Saved trap-state word of the selected level |
| rd_tpc_o | output | PC_W | Saved trap PC of the selected level |
| rd_tnpc_o | output | PC_W | Saved trap NPC of the selected level |
| rd_htstate_o | output | 12 | Saved hyper-state of the selected level |
| rd_tt_o | output | 9 | Saved trap type of the selected level |

## Verification
The bench targets the ends of each trap-type range: 0x024 next to 0x023, 0x080 and 0x0BF for spill, 0x0C0 and 0x0FF for fill, and 0x07F and 0x100 just outside them. A design that decoded a range one entry short would move the window for one of these types or fail to move it. Window wrap is exercised upward from window 7 and from a spill sum above NWIN, and downward from window 0. A missing modulo would show a pointer of eight or more, or an underflow to 31. The bench also sends a seventh trap after six accepted ones. A design that wrote that request anyway would overwrite level six or alter the live outputs, and the bench checks both. Reset is applied over filled save levels to confirm that no stale word survives it.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int GL_W   = 3;
    localparam int CCR_W  = 8;
    localparam int ASI_W  = 8;
    localparam int PS_W   = 13;
    localparam int HPS_W  = 12;
    localparam int CWP_W  = 5;
    localparam int TT_W   = 9;
    localparam int TSW_W  = 64;

    // processor-state bit positions touched on entry
    localparam int PS_CLE = 9;
    localparam int PS_TLE = 8;
    localparam int PS_PEF = 4;
    localparam int PS_AM  = 3;
    localparam int PS_PRV = 2;
    localparam int PS_IE  = 1;

    typedef enum logic [1:0] {
        WIN_KEEP  = 2'd0,
        WIN_CLEAN = 2'd1,
        WIN_SPILL = 2'd2,
        WIN_FILL  = 2'd3
    } win_move_e;

    typedef struct packed {
        logic [GL_W-1:0]  gl;
        logic [CCR_W-1:0] ccr;
        logic [ASI_W-1:0] asi;
        logic [PS_W-1:0]  pstate;
        logic [CWP_W-1:0] cwp;
    } live_snap_t;

    function automatic logic [TSW_W-1:0] pack_tstate(input live_snap_t s);
        logic [TSW_W-1:0] w;
        w        = '0;
        w[42:40] = s.gl;
        w[39:32] = s.ccr;
        w[31:24] = s.asi;
        w[20:8]  = s.pstate;
        w[4:0]   = s.cwp;
        return w;
    endfunction

    function automatic win_move_e classify_tt(input logic [TT_W-1:0] tt);
        win_move_e k;
        if (tt == 9'h024)
            k = WIN_CLEAN;
        else if (tt >= 9'h080 && tt <= 9'h0BF)
            k = WIN_SPILL;
        else if (tt >= 9'h0C0 && tt <= 9'h0FF)
            k = WIN_FILL;
        else
            k = WIN_KEEP;
        return k;
    endfunction

    function automatic logic [PS_W-1:0] entry_pstate(input logic [PS_W-1:0] ps);
        logic [PS_W-1:0] n;
        n         = ps;
        n[PS_PEF] = 1'b1;
        n[PS_AM]  = 1'b0;
        n[PS_PRV] = 1'b1;
        n[PS_CLE] = ps[PS_TLE];
        n[PS_IE]  = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/trap_win_step.sv
module trap_win_step
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [TT_W-1:0]  tt_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam int SUM_W = CWP_W + 2;
    localparam logic [SUM_W-1:0] NW = SUM_W'(NWIN);

    win_move_e       kind;
    logic [SUM_W-1:0] sum;

    always_comb begin
        kind = classify_tt(tt_i);
        case (kind)
            WIN_CLEAN: sum = SUM_W'(cwp_i) + SUM_W'(1);
            WIN_SPILL: sum = SUM_W'(cwp_i) + SUM_W'(cansave_i) + SUM_W'(2);
            WIN_FILL:  sum = SUM_W'(cwp_i) + NW - SUM_W'(1);
            default:   sum = SUM_W'(cwp_i);
        endcase
        if (kind == WIN_KEEP)
            cwp_o = cwp_i;
        else
            cwp_o = CWP_W'(sum % NW);
    end
endmodule

// File: rtl/trap_save_stack.sv
module trap_save_stack
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int PC_W   = 64,
    parameter int TL_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [TL_W-1:0]   wr_lvl_i,
    input  logic [TSW_W-1:0]  wr_tstate_i,
    input  logic [PC_W-1:0]   wr_tpc_i,
    input  logic [PC_W-1:0]   wr_tnpc_i,
    input  logic [HPS_W-1:0]  wr_htstate_i,
    input  logic [TT_W-1:0]   wr_tt_i,
    input  logic [TL_W-1:0]   rd_lvl_i,
    output logic [TSW_W-1:0]  rd_tstate_o,
    output logic [PC_W-1:0]   rd_tpc_o,
    output logic [PC_W-1:0]   rd_tnpc_o,
    output logic [HPS_W-1:0]  rd_htstate_o,
    output logic [TT_W-1:0]   rd_tt_o
);
    logic [TSW_W-1:0] tstate_q  [1:MAX_TL];
    logic [PC_W-1:0]  tpc_q     [1:MAX_TL];
    logic [PC_W-1:0]  tnpc_q    [1:MAX_TL];
    logic [HPS_W-1:0] htstate_q [1:MAX_TL];
    logic [TT_W-1:0]  tt_q      [1:MAX_TL];

    for (genvar lv = 1; lv <= MAX_TL; lv++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                tstate_q[lv]  <= '0;
                tpc_q[lv]     <= '0;
                tnpc_q[lv]    <= '0;
                htstate_q[lv] <= '0;
                tt_q[lv]      <= '0;
            end else if (wr_en_i && wr_lvl_i == TL_W'(lv)) begin
                tstate_q[lv]  <= wr_tstate_i;
                tpc_q[lv]     <= wr_tpc_i;
                tnpc_q[lv]    <= wr_tnpc_i;
                htstate_q[lv] <= wr_htstate_i;
                tt_q[lv]      <= wr_tt_i;
            end
        end
    end

    always_comb begin
        rd_tstate_o  = '0;
        rd_tpc_o     = '0;
        rd_tnpc_o    = '0;
        rd_htstate_o = '0;
        rd_tt_o      = '0;
        for (int lv = 1; lv <= MAX_TL; lv++) begin
            if (rd_lvl_i == TL_W'(lv)) begin
                rd_tstate_o  = tstate_q[lv];
                rd_tpc_o     = tpc_q[lv];
                rd_tnpc_o    = tnpc_q[lv];
                rd_htstate_o = htstate_q[lv];
                rd_tt_o      = tt_q[lv];
            end
        end
    end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_entry_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 6,
    parameter int MAX_GL = 3,
    parameter int PC_W   = 64,
    parameter int TL_W   = $clog2(MAX_TL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_i,
    input  logic [TT_W-1:0]   tt_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   npc_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [ASI_W-1:0]  asi_i,
    input  logic [PS_W-1:0]   pstate_i,
    input  logic [HPS_W-1:0]  hpstate_i,
    input  logic [CWP_W-1:0]  cwp_i,
    input  logic [CWP_W-1:0]  cansave_i,
    input  logic [GL_W-1:0]   gl_i,
    input  logic [TL_W-1:0]   rd_lvl_i,
    output logic [TL_W-1:0]   tl_o,
    output logic [GL_W-1:0]   gl_o,
    output logic [CWP_W-1:0]  cwp_o,
    output logic [PS_W-1:0]   pstate_o,
    output logic              err_o,
    output logic [TSW_W-1:0]  rd_tstate_o,
    output logic [PC_W-1:0]   rd_tpc_o,
    output logic [PC_W-1:0]   rd_tnpc_o,
    output logic [HPS_W-1:0]  rd_htstate_o,
    output logic [TT_W-1:0]   rd_tt_o
);
    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);
    localparam logic [GL_W:0]   GL_TOP = (GL_W+1)'(MAX_GL);

    logic [TL_W-1:0]  tl_q;
    logic [GL_W-1:0]  gl_q;
    logic [CWP_W-1:0] cwp_q;
    logic [PS_W-1:0]  pstate_q;
    logic             err_q;

    logic             accept;
    logic             refuse;
    logic [TL_W-1:0]  tl_next;
    logic [GL_W:0]    gl_inc;
    logic [GL_W-1:0]  gl_next;
    logic [CWP_W-1:0] cwp_next;
    live_snap_t       snap;
    logic [TSW_W-1:0] tstate_word;

    always_comb begin
        accept      = trap_i && (tl_q != TL_TOP);
        refuse      = trap_i && (tl_q == TL_TOP);
        tl_next     = tl_q + TL_W'(1);
        gl_inc      = (GL_W+1)'(gl_i) + (GL_W+1)'(1);
        gl_next     = (gl_inc > GL_TOP) ? GL_W'(GL_TOP) : GL_W'(gl_inc);
        snap.gl     = gl_i;
        snap.ccr    = ccr_i;
        snap.asi    = asi_i;
        snap.pstate = pstate_i;
        snap.cwp    = cwp_i;
        tstate_word = pack_tstate(snap);
    end

    trap_win_step #(.NWIN(NWIN)) u_win (
        .tt_i      (tt_i),
        .cwp_i     (cwp_i),
        .cansave_i (cansave_i),
        .cwp_o     (cwp_next)
    );

    trap_save_stack #(.MAX_TL(MAX_TL), .PC_W(PC_W), .TL_W(TL_W)) u_stack (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (accept),
        .wr_lvl_i     (tl_next),
        .wr_tstate_i  (tstate_word),
        .wr_tpc_i     (pc_i),
        .wr_tnpc_i    (npc_i),
        .wr_htstate_i (hpstate_i),
        .wr_tt_i      (tt_i),
        .rd_lvl_i     (rd_lvl_i),
        .rd_tstate_o  (rd_tstate_o),
        .rd_tpc_o     (rd_tpc_o),
        .rd_tnpc_o    (rd_tnpc_o),
        .rd_htstate_o (rd_htstate_o),
        .rd_tt_o      (rd_tt_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tl_q     <= '0;
            gl_q     <= '0;
            cwp_q    <= '0;
            pstate_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= refuse;
            if (accept) begin
                tl_q     <= tl_next;
                gl_q     <= gl_next;
                cwp_q    <= cwp_next;
                pstate_q <= entry_pstate(pstate_i);
            end
        end
    end

    assign tl_o     = tl_q;
    assign gl_o     = gl_q;
    assign cwp_o    = cwp_q;
    assign pstate_o = pstate_q;
    assign err_o    = err_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_entry_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 6,
    parameter int MAX_GL = 3,
    parameter int TL_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             trap_i,
    input logic [PS_W-1:0]  pstate_i,
    input logic [TL_W-1:0]  tl_o,
    input logic [GL_W-1:0]  gl_o,
    input logic [CWP_W-1:0] cwp_o,
    input logic [PS_W-1:0]  pstate_o,
    input logic             err_o
);
    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

    AST_TL_STEP: assert property (@(posedge clk) disable iff (rst)
        trap_i && tl_o != TL_TOP |=> tl_o == $past(tl_o) + TL_W'(1)); // R2
    AST_PS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        trap_i && tl_o != TL_TOP |=> pstate_o[4] && !pstate_o[3] && pstate_o[2] && !pstate_o[1]); // R5
    AST_LE_COPY: assert property (@(posedge clk) disable iff (rst)
        trap_i && tl_o != TL_TOP |=> pstate_o[9] == $past(pstate_i[8]) && pstate_o[8] == $past(pstate_i[8])); // R6
    AST_CWP_RANGE: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> cwp_o < CWP_W'(NWIN)); // R10
    AST_GL_CAP: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> gl_o <= GL_W'(MAX_GL)); // R11
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        trap_i && tl_o == TL_TOP |=> err_o && $stable(tl_o) && $stable(cwp_o) && $stable(pstate_o)); // R12
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !trap_i |=> !err_o); // R12
    AST_NO_TRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trap_i |=> $stable(tl_o) && $stable(gl_o) && $stable(cwp_o) && $stable(pstate_o)); // R13
endmodule

bind trap_entry trap_entry_chk #(
    .NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .TL_W(TL_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trap_i   (trap_i),
    .pstate_i (pstate_i),
    .tl_o     (tl_o),
    .gl_o     (gl_o),
    .cwp_o    (cwp_o),
    .pstate_o (pstate_o),
    .err_o    (err_o)
);

// File: tb/sim_trap_entry.sv
module sim_trap_entry;
    localparam int NWIN = 8, MAX_TL = 6, MAX_GL = 3, PC_W = 64, TL_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trap_i = 1'b0;
    logic [8:0] tt_i = '0;
    logic [63:0] pc_i = '0, npc_i = '0;
    logic [7:0] ccr_i = '0, asi_i = '0;
    logic [12:0] pstate_i = '0;
    logic [11:0] hpstate_i = '0;
    logic [4:0] cwp_i = '0, cansave_i = '0;
    logic [2:0] gl_i = '0;
    logic [TL_W-1:0] rd_lvl_i = '0;
    logic [TL_W-1:0] tl_o;
    logic [2:0] gl_o;
    logic [4:0] cwp_o;
    logic [12:0] pstate_o;
    logic err_o;
    logic [63:0] rd_tstate_o, rd_tpc_o, rd_tnpc_o;
    logic [11:0] rd_htstate_o;
    logic [8:0] rd_tt_o;

    int n_run = 0, n_fail = 0;
    int exp_tl = 0;

    always #10 clk = ~clk;

    trap_entry #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .PC_W(PC_W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; trap_i = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        exp_tl = 0;
    endtask

    // one accepted trap with full checking of live outputs and saved level
    task automatic trap_case(input logic [8:0] tt, input logic [4:0] cwp, input logic [4:0] cs,
                             input logic [2:0] gl, input logic [12:0] ps, input logic [4:0] exp_cwp,
                             input string req);
        logic [63:0] exp_ts, pc, npc;
        logic [12:0] exp_ps;
        logic [2:0]  exp_gl;
        pc  = 64'h4000_0000_0000 + 64'(tt) * 16;
        npc = pc + 4;
        @(negedge clk);
        tt_i = tt; cwp_i = cwp; cansave_i = cs; gl_i = gl; pstate_i = ps;
        pc_i = pc; npc_i = npc; ccr_i = 8'hA5 ^ tt[7:0]; asi_i = 8'h3C + tt[7:0];
        hpstate_i = 12'h800 | 12'(tt); trap_i = 1'b1;
        @(negedge clk);
        trap_i = 1'b0;
        exp_tl++;
        exp_ps = ps | 13'h014;
        exp_ps[3] = 1'b0; exp_ps[1] = 1'b0; exp_ps[9] = ps[8];
        exp_gl = (gl >= 3'(MAX_GL)) ? 3'(MAX_GL) : gl + 3'd1;
        exp_ts = (64'(gl) << 40) | (64'(ccr_i) << 32) | (64'(asi_i) << 24) | (64'(ps) << 8) | 64'(cwp);
        rd_lvl_i = TL_W'(exp_tl);
        #1;
        chk(tl_o == TL_W'(exp_tl), "R2 trap level", 64'(tl_o), 64'(exp_tl));
        chk(cwp_o == exp_cwp, req, 64'(cwp_o), 64'(exp_cwp));
        chk(pstate_o == exp_ps, "R5/R6 pstate", 64'(pstate_o), 64'(exp_ps));
        chk(gl_o == exp_gl, "R11 gl", 64'(gl_o), 64'(exp_gl));
        chk(rd_tstate_o == exp_ts, "R3 tstate", rd_tstate_o, exp_ts);
        chk(rd_tpc_o == pc && rd_tnpc_o == npc, "R4 tpc/tnpc", rd_tpc_o, pc);
        chk(rd_htstate_o == hpstate_i && rd_tt_o == tt, "R4 htstate/tt", 64'(rd_tt_o), 64'(tt));
        chk(err_o == 1'b0, "R12 no err", 64'(err_o), 0);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(tl_o == 0 && gl_o == 0 && cwp_o == 0 && pstate_o == 0 && err_o == 0, "R1 reset live", 64'(tl_o), 0);
        for (int lv = 0; lv <= MAX_TL; lv++) begin
            rd_lvl_i = TL_W'(lv); #1;
            chk(rd_tstate_o == 0 && rd_tpc_o == 0 && rd_tt_o == 0, "R1 reset saved", rd_tstate_o, 0);
        end
    endtask

    task automatic t_fill_stack();
        trap_case(9'h010, 5'd3, 5'd0, 3'd1, 13'h0100, 5'd3, "R9 other tt keeps cwp");
        trap_case(9'h024, 5'd7, 5'd0, 3'd3, 13'h120A, 5'd0, "R7/R10 clean wrap");
        trap_case(9'h085, 5'd5, 5'd3, 3'd0, 13'h0000, 5'd2, "R8/R10 spill wrap");
        trap_case(9'h0C0, 5'd0, 5'd1, 3'd2, 13'h1FFF, 5'd7, "R9/R10 fill wrap");
        trap_case(9'h0BF, 5'd6, 5'd7, 3'd2, 13'h0300, 5'd7, "R8 spill top edge");
        trap_case(9'h0FF, 5'd3, 5'd0, 3'd0, 13'h0001, 5'd2, "R9 fill top edge");
        rd_lvl_i = 3'd7; #1;
        chk(rd_tstate_o == 0 && rd_tpc_o == 0, "R2 read above MAX_TL", rd_tstate_o, 0);
    endtask

    task automatic t_full();
        logic [63:0] ts6, pc6;
        logic [4:0]  cwp_before;
        logic [12:0] ps_before;
        rd_lvl_i = 3'd6; #1;
        ts6 = rd_tstate_o; pc6 = rd_tpc_o;
        cwp_before = cwp_o; ps_before = pstate_o;
        @(negedge clk);
        tt_i = 9'h024; cwp_i = 5'd1; pstate_i = 13'h0; gl_i = 3'd0;
        pc_i = 64'hDEAD; npc_i = 64'hBEEF; trap_i = 1'b1;
        @(negedge clk);
        trap_i = 1'b0; #1;
        chk(err_o == 1'b1, "R12 err raised", 64'(err_o), 1);
        chk(tl_o == 3'd6, "R12 tl held", 64'(tl_o), 6);
        chk(cwp_o == cwp_before && pstate_o == ps_before, "R12 live held", 64'(cwp_o), 64'(cwp_before));
        chk(rd_tstate_o == ts6 && rd_tpc_o == pc6, "R12 level 6 intact", rd_tpc_o, pc6);
        @(negedge clk); #1;
        chk(err_o == 1'b0, "R12 err one cycle", 64'(err_o), 0);
    endtask

    task automatic t_hold_and_edges();
        logic [4:0] c0;
        do_reset();
        trap_case(9'h100, 5'd4, 5'd2, 3'd1, 13'h0000, 5'd4, "R9 tt 0x100 keeps cwp");
        trap_case(9'h07F, 5'd5, 5'd2, 3'd1, 13'h0000, 5'd5, "R9 tt 0x07F keeps cwp");
        trap_case(9'h023, 5'd6, 5'd2, 3'd1, 13'h0000, 5'd6, "R7 tt 0x023 keeps cwp");
        trap_case(9'h080, 5'd0, 5'd0, 3'd1, 13'h0000, 5'd2, "R8 spill low edge");
        c0 = cwp_o;
        @(negedge clk);
        tt_i = 9'h0C0; cwp_i = 5'd5; gl_i = 3'd2; pstate_i = 13'h1FFF;
        repeat (3) @(negedge clk);
        #1;
        chk(tl_o == 3'd4 && cwp_o == c0 && gl_o == 3'd2, "R13 hold without trap", 64'(cwp_o), 64'(c0));
        t_reset();
    endtask

    initial begin
        t_reset();
        t_fill_stack();
        t_full();
        t_hold_and_edges();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20ns * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule